// File: doc/BRIEF.md
# Boundary Scan Cell Chain with Parallel Hold Latches

This block is a chain of boundary cells that sits between a device's core logic and its pads. Each cell has two storage elements. The first is a capture/shift flop clocked on the rising test clock. The second is a hold latch that loads from that flop on the falling test clock. A separate test-access state machine drives the block. It supplies one-cycle state strobes for capture, shift, update and test-logic-reset, together with the currently decoded instruction code.

While the chain is selected, a capture strobe loads the parallel pin-input values into the flops. A shift strobe moves the chain one place toward the serial output and brings in the serial input at cell 0. An update strobe copies the flops into the hold latches on the next falling edge. At all other times the hold latches keep their value, so the pins see no ripple while data streams through the chain. While the external-test instruction is active, the latches drive the pin-facing outputs. Under any other instruction, the core signals pass straight through.

Top module: `bscan_chain`

## Requirements
- R1: On a rising `tck` with `capture_dr` high, the flops load `pin_in` if `instr` equals `EXTEST_CODE` (default 4'h0) or `SAMPLE_CODE` (default 4'h1). Under any other code the capture strobe leaves them unchanged.
- R2: On a rising `tck` with `shift_dr` high, no capture, and a selecting instruction, cell 0 takes `tdi` and cell i takes cell i-1. `tdo` always shows cell N-1, the last cell. A shift strobe under a non-selecting instruction has no effect.
- R3: On a falling `tck` with `update_dr` high and a selecting instruction, the hold latches take the flop contents. Under a non-selecting instruction the update strobe leaves the latches unchanged.
- R4: The hold latches change only in the cases named in R3 and R7. Capture and shift activity leaves `pin_out` unchanged while external test is active.
- R5: On a rising edge with neither a selected capture nor a selected shift (idle, pause, exit or update), the flops keep their values.
- R6: With `instr` equal to `EXTEST_CODE`, `extest_mode` is 1 and `pin_out` equals the hold latches. Under any other code, `extest_mode` is 0 and `pin_out` equals `core_out`.
- R7: On a falling `tck` with `tlr` high, the hold latches load `SAFE_VAL`. This takes priority over an update.
- R8: While the synchronous reset `rst` is high, the flops clear to 0 on rising edges, so `tdo` reads 0, and the latches load `SAFE_VAL` on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; flops on rising edge, latches on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | Test-logic-reset state strobe |
| capture_dr | input | 1 | Capture state strobe |
| shift_dr | input | 1 | Shift state strobe |
| update_dr | input | 1 | Update state strobe |
| instr | input | IR_W | Current instruction code |
| tdi | input | 1 | Serial data into cell 0 |
| pin_in | input | N | Parallel values observed at the pins |
| core_out | input | N | Core signals heading to the pins |
| tdo | output | 1 | Serial data from the last cell |
| pin_out | output | N | Values driven toward the pins |
| extest_mode | output | 1 | High while external test owns the pins |

## Verification
Most faults in the flops reach the serial output within at most N shift cycles. For that reason the bench streams every captured or shifted pattern out through `tdo`, bit by bit, against a reference chain. A hold latch that changes at the wrong time shows at `pin_out` under external test right away. The bench therefore samples `pin_out` during shifting, between the update strobe and its falling edge, and after updates or captures under non-selecting codes. A wrong decode shows in the same cycle as a stale or swapped `pin_out` and `extest_mode`.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } chain_op_e;
endpackage

// File: rtl/bscan_ir_decode.sv
module bscan_ir_decode #(
  parameter int              IR_W        = 4,
  parameter logic [IR_W-1:0] EXTEST_CODE = '0,
  parameter logic [IR_W-1:0] SAMPLE_CODE = 'd1
) (
  input  logic [IR_W-1:0] instr,
  output logic            sel,
  output logic            extest
);
  always_comb begin
    extest = (instr == EXTEST_CODE);
    sel    = extest || (instr == SAMPLE_CODE);
  end
endmodule

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain #(
  parameter int N = 8
) (
  input  logic                 tck,
  input  logic                 rst,
  input  bscan_pkg::chain_op_e op,
  input  logic                 tdi,
  input  logic [N-1:0]         pin_in,
  output logic [N-1:0]         stage_q
);
  logic [N-1:0] serial_in;

  assign serial_in = {stage_q[N-2:0], tdi};

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge tck) begin
      if (rst) begin
        stage_q[i] <= 1'b0;
      end else begin
        case (op)
          bscan_pkg::OP_CAPTURE: stage_q[i] <= pin_in[i];
          bscan_pkg::OP_SHIFT:   stage_q[i] <= serial_in[i];
          default:               stage_q[i] <= stage_q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/bscan_update_bank.sv
module bscan_update_bank #(
  parameter int           N        = 8,
  parameter logic [N-1:0] SAFE_VAL = '0
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         tlr,
  input  logic         load,
  input  logic [N-1:0] stage_q,
  output logic [N-1:0] latch_q
);
  for (genvar i = 0; i < N; i++) begin : g_hold
    always_ff @(negedge tck) begin
      if (rst || tlr) begin
        latch_q[i] <= SAFE_VAL[i];
      end else if (load) begin
        latch_q[i] <= stage_q[i];
      end
    end
  end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int              N           = 8,
  parameter int              IR_W        = 4,
  parameter logic [IR_W-1:0] EXTEST_CODE = '0,
  parameter logic [IR_W-1:0] SAMPLE_CODE = 'd1,
  parameter logic [N-1:0]    SAFE_VAL    = '0
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tlr,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic [IR_W-1:0] instr,
  input  logic            tdi,
  input  logic [N-1:0]    pin_in,
  input  logic [N-1:0]    core_out,
  output logic            tdo,
  output logic [N-1:0]    pin_out,
  output logic            extest_mode
);
  import bscan_pkg::*;

  logic         sel_w;
  logic         extest_w;
  chain_op_e    op_w;
  logic [N-1:0] stage_q;
  logic [N-1:0] latch_q;

  bscan_ir_decode #(
    .IR_W(IR_W), .EXTEST_CODE(EXTEST_CODE), .SAMPLE_CODE(SAMPLE_CODE)
  ) dec_i (
    .instr(instr), .sel(sel_w), .extest(extest_w)
  );

  always_comb begin
    if (sel_w && capture_dr)    op_w = OP_CAPTURE;
    else if (sel_w && shift_dr) op_w = OP_SHIFT;
    else                        op_w = OP_HOLD;
  end

  bscan_shift_chain #(.N(N)) chain_i (
    .tck(tck), .rst(rst), .op(op_w), .tdi(tdi),
    .pin_in(pin_in), .stage_q(stage_q)
  );

  bscan_update_bank #(.N(N), .SAFE_VAL(SAFE_VAL)) bank_i (
    .tck(tck), .rst(rst), .tlr(tlr), .load(update_dr && sel_w),
    .stage_q(stage_q), .latch_q(latch_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_pinmux
    assign pin_out[i] = extest_w ? latch_q[i] : core_out[i];
  end

  assign tdo         = stage_q[N-1];
  assign extest_mode = extest_w;
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int           N        = 8,
  parameter logic [N-1:0] SAFE_VAL = '0
) (
  input logic         tck,
  input logic         rst,
  input logic         tlr,
  input logic         capture_dr,
  input logic         shift_dr,
  input logic         update_dr,
  input logic         sel_w,
  input logic         extest_w,
  input logic         tdi,
  input logic [N-1:0] pin_in,
  input logic [N-1:0] core_out,
  input logic [N-1:0] stage_q,
  input logic [N-1:0] latch_q,
  input logic [N-1:0] pin_out
);
  assert_capture_R1: assert property (@(posedge tck) disable iff (rst)
    (capture_dr && sel_w) |=> stage_q == $past(pin_in));

  assert_shift_R2: assert property (@(posedge tck) disable iff (rst)
    (shift_dr && sel_w && !capture_dr) |=>
      stage_q == {$past(stage_q[N-2:0]), $past(tdi)});

  assert_hold_R5: assert property (@(posedge tck) disable iff (rst)
    !(sel_w && (capture_dr || shift_dr)) |=> $stable(stage_q));

  assert_update_R3: assert property (@(negedge tck) disable iff (rst)
    (update_dr && sel_w && !tlr) |=> latch_q == $past(stage_q));

  assert_latch_still_R4: assert property (@(negedge tck) disable iff (rst)
    (!(update_dr && sel_w) && !tlr) |=> $stable(latch_q));

  assert_safe_R7: assert property (@(negedge tck) disable iff (rst)
    tlr |=> latch_q == SAFE_VAL);

  assert_drive_R6: assert property (@(posedge tck) disable iff (rst)
    extest_w |-> pin_out == latch_q);

  assert_pass_R6: assert property (@(posedge tck) disable iff (rst)
    !extest_w |-> pin_out == core_out);
endmodule

bind bscan_chain bscan_chain_chk #(.N(N), .SAFE_VAL(SAFE_VAL)) chk_i (
  .tck(tck), .rst(rst), .tlr(tlr), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .update_dr(update_dr), .sel_w(sel_w),
  .extest_w(extest_w), .tdi(tdi), .pin_in(pin_in), .core_out(core_out),
  .stage_q(stage_q), .latch_q(latch_q), .pin_out(pin_out)
);

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;
  localparam int         N      = 8;
  localparam logic [3:0] EX     = 4'h0;
  localparam logic [3:0] SA     = 4'h1;
  localparam logic [3:0] IDC    = 4'h2;
  localparam logic [3:0] BYP    = 4'hF;
  localparam logic [7:0] SAFE   = 8'hC3;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic rst = 1'b1, tlr = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic [3:0] instr = BYP;
  logic [N-1:0] pin_in = '0, core_out = '0;
  logic tdo, extest_mode;
  logic [N-1:0] pin_out;

  bscan_chain #(.N(N), .IR_W(4), .EXTEST_CODE(EX), .SAMPLE_CODE(SA),
                .SAFE_VAL(SAFE)) dut_i (
    .tck(tck), .rst(rst), .tlr(tlr), .capture_dr(cap), .shift_dr(sh),
    .update_dr(upd), .instr(instr), .tdi(tdi), .pin_in(pin_in),
    .core_out(core_out), .tdo(tdo), .pin_out(pin_out),
    .extest_mode(extest_mode)
  );

  int checks = 0, errors = 0;
  logic exp_q[$];
  logic [N-1:0] model = '0;
  logic [N-1:0] lat_exp = SAFE;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit selected();
    return (instr == EX) || (instr == SA);
  endfunction

  task automatic step(input logic c, input logic s, input logic u,
                      input logic t, input logic d);
    @(negedge tck); #1;
    cap = c; sh = s; upd = u; tlr = t; tdi = d;
    if (selected() && c) model = pin_in;
    else if (selected() && s) begin
      exp_q.push_back(model[N-1]);
      model = {model[N-2:0], d};
    end
    if (t) lat_exp = SAFE;
    else if (u && selected()) lat_exp = model;
  endtask

  task automatic set_ir(input logic [3:0] v);
    @(negedge tck); #1;
    cap = 0; sh = 0; upd = 0; tlr = 0; instr = v;
  endtask

  task automatic shift_bits(input logic [N-1:0] din);
    for (int k = 0; k < N; k++) step(0, 1, 0, 0, din[k]);
    step(0, 0, 0, 0, 0);
  endtask

  // monitor: compares the serial output before each selected shift edge
  initial begin
    forever begin
      @(negedge tck); #3;
      if (sh && selected() && !rst) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 actual=%0b expected=<none>", tdo);
        end else begin
          logic e;
          e = exp_q.pop_front();
          if (tdo !== e) begin
            errors++;
            $display("FAIL R1/R2 tdo actual=%0b expected=%0b", tdo, e);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    core_out = 8'h55;
    repeat (3) @(posedge tck);
    @(negedge tck); #1; rst = 0;
    #1;
    check("R8 tdo after reset", tdo, 0);
    check("R6 bypass pass-through", pin_out, 8'h55);
    check("R6 mode low", extest_mode, 0);
    set_ir(EX); #1;
    check("R7 latch safe after reset", pin_out, SAFE);
    check("R6 mode high", extest_mode, 1);

    // R1 R2: sample capture and stream out
    set_ir(SA); #1;
    check("R6 sample pass-through", pin_out, 8'h55);
    pin_in = 8'h3C;
    step(1, 0, 0, 0, 0);
    shift_bits(8'h96);

    // R1 R2: capture and shift ignored under IDCODE
    set_ir(IDC);
    pin_in = 8'hFF;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 1); step(0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    set_ir(SA);
    shift_bits(8'h00);

    // R4 R3 R5: extest shift, pause, update
    set_ir(EX);
    shift_bits(8'hE1);
    #1; check("R4 latch held after shift", pin_out, lat_exp);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    #1; check("R4 before falling edge", pin_out, SAFE);
    @(posedge tck); #1;
    check("R4 after rising edge in update", pin_out, SAFE);
    step(0, 0, 0, 0, 0); #1;
    check("R3 R5 latch after update", pin_out, lat_exp);

    // R4 R1: extest capture does not touch latches
    core_out = 8'hAA;
    pin_in = 8'h0F;
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0); #1;
    check("R4 latch after capture", pin_out, lat_exp);
    shift_bits(8'h33);

    // R3: update under IDCODE ignored
    set_ir(IDC); #1;
    check("R6 idcode pass-through", pin_out, 8'hAA);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    set_ir(EX); #1;
    check("R3 update ignored unselected", pin_out, lat_exp);

    // R7: test-logic-reset
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0); #1;
    check("R7 tlr loads safe", pin_out, SAFE);

    // R7 priority over update
    shift_bits(8'h5A);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0); #1;
    check("R7 tlr beats update", pin_out, SAFE);

    // R8: reset mid-run
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0); #1;
    check("R3 update loads stages", pin_out, lat_exp);
    @(negedge tck); #1; rst = 1;
    repeat (2) @(posedge tck);
    @(negedge tck); #1; rst = 0; model = '0; lat_exp = SAFE; #1;
    check("R8 tdo cleared", tdo, 0);
    check("R8 latch safe", pin_out, SAFE);
    check("R2 queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule